// File: doc/BRIEF.md
# Modem Status Register

This block sits in a UART's host register file and watches the four incoming modem handshake lines: carrier detect, ring indicator, data-set-ready and clear-to-send. The pins arrive asynchronously. Each pin first passes through a synchronizer. The block then reports the inverted pin levels in the upper nibble of an 8-bit register. In the lower nibble it keeps sticky change flags, which stay set until the host reads the register. Any pending flag raises a level-sensitive interrupt.

In internal loopback mode the pins are ignored. The four status bits are instead fed from the UART's modem-control output bits, using a crossed mapping. The status register is read-only. A host write to its address lands in a separate feature control register that shares the address. Here that register is plain 8-bit storage, and its contents are exposed on a port.

Top module: `modem_status_reg`

## Requirements
- R1: After reset the read data, the interrupt, all change flags and the feature register are zero. This holds when the pins rest high.
- R2: In normal mode, bits 7, 6, 5 and 4 of the status register return the inverted levels of the pins, in this order: carrier detect, ring indicator, data-set-ready, clear-to-send.
- R3: In loopback mode the pins have no effect. Bit 7 shows control bit 3, bit 6 shows control bit 2, bit 5 shows control bit 0 and bit 4 shows control bit 1.
- R4: Bits 3, 1 and 0 are the change flags for status bits 7, 5 and 4. Each is set when its status bit changes in either direction.
- R5: Bit 2 is set only when status bit 6 goes from 0 to 1. A 1-to-0 change of that bit leaves bit 2 clear.
- R6: A read strobe at the status address returns the status bits and the flags as they stood before the read. It then clears all four flags.
- R7: The interrupt output is high exactly when at least one flag is set. It falls in the cycle after a clearing read if no new change has arrived.
- R8: A change that lands in the same cycle as a clearing read leaves its flag set. The interrupt stays high.
- R9: Entering or leaving loopback mode sets the flags of every status bit that changes as a result, as a pin change would.
- R10: A write strobe at the status address loads the feature register and leaves the status bits and flags untouched. A write to any other address leaves the feature register unchanged.
- R11: A read strobe at any other address returns zero and does not clear any flag.
- R12: A pin change reaches the flags on the third rising clock edge after it, and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Register address |
| host_rd | input | 1 | Read strobe, one cycle |
| host_wr | input | 1 | Write strobe, one cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, registered on the read strobe |
| pin_cd | input | 1 | Carrier detect pin, asynchronous |
| pin_ri | input | 1 | Ring indicator pin, asynchronous |
| pin_dsr | input | 1 | Data-set-ready pin, asynchronous |
| pin_cts | input | 1 | Clear-to-send pin, asynchronous |
| loop_en | input | 1 | Loopback mode select |
| ctrl_out | input | 4 | Modem-control output bits: [0] terminal ready, [1] request to send, [2] user output 1, [3] user output 2 |
| feat_ctrl | output | 8 | Contents of the feature control register |
| msi_irq | output | 1 | Modem-status interrupt, active high |

## Verification
Two events can fall in the same clock edge: a clearing read of the status register, and a fresh status change that has to set a flag. The bench provokes this in loopback mode. On one falling edge it raises the read strobe and, at the same time, toggles a control bit. The returned byte must show the old flags, and a second read must show the new flag still set with the interrupt held high. Two more pairs of simultaneous events are also judged: a write to the shared address while flags are pending, and a read at a foreign address while flags are pending.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int NLINES = 4;
    localparam int REG_W  = 2 * NLINES;

    // status / flag bit positions inside each nibble
    localparam int IDX_CD  = 3;
    localparam int IDX_RI  = 2;
    localparam int IDX_DSR = 1;
    localparam int IDX_CTS = 0;

    // only the ring line flags on a rising status edge
    localparam logic [NLINES-1:0] RISE_ONLY_MASK = 4'b0100;

    typedef struct packed {
        logic [NLINES-1:0] stat;
        logic [NLINES-1:0] flag;
        logic [REG_W-1:0]  rdata;
        logic [REG_W-1:0]  feat;
        logic              irq;
    } msr_state_t;

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int          WIDTH   = 4,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain_q [STAGES];
    logic [WIDTH-1:0] chain_d [STAGES];

    always_comb begin
        chain_d[0] = d;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= RST_VAL;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                chain_q[s] <= chain_d[s];
            end
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/msr_src_sel.sv
module msr_src_sel
    import msr_pkg::*;
(
    input  logic              loop_en,
    input  logic [NLINES-1:0] ctrl_out,
    input  logic [NLINES-1:0] pin_sync,
    output logic [NLINES-1:0] stat
);
    logic [NLINES-1:0] loop_stat;

    always_comb begin
        loop_stat          = '0;
        loop_stat[IDX_CD]  = ctrl_out[3];
        loop_stat[IDX_RI]  = ctrl_out[2];
        loop_stat[IDX_DSR] = ctrl_out[0];
        loop_stat[IDX_CTS] = ctrl_out[1];
        stat = loop_en ? loop_stat : ~pin_sync;
    end
endmodule

// File: rtl/msr_delta_detect.sv
module msr_delta_detect
    import msr_pkg::*;
#(
    parameter logic [NLINES-1:0] RISE_ONLY = RISE_ONLY_MASK
) (
    input  logic [NLINES-1:0] cur,
    input  logic [NLINES-1:0] prev,
    output logic [NLINES-1:0] evt
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        if (RISE_ONLY[i]) begin : g_rise
            assign evt[i] = cur[i] & ~prev[i];
        end else begin : g_any
            assign evt[i] = cur[i] ^ prev[i];
        end
    end
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
    import msr_pkg::*;
#(
    parameter int              ADDR_W      = 3,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 3'd6,
    parameter int              SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [REG_W-1:0]  host_wdata,
    output logic [REG_W-1:0]  host_rdata,
    input  logic              pin_cd,
    input  logic              pin_ri,
    input  logic              pin_dsr,
    input  logic              pin_cts,
    input  logic              loop_en,
    input  logic [NLINES-1:0] ctrl_out,
    output logic [REG_W-1:0]  feat_ctrl,
    output logic              msi_irq
);
    msr_state_t st_q, st_d;

    logic [NLINES-1:0] pin_vec;
    logic [NLINES-1:0] pin_sync;
    logic [NLINES-1:0] cur_stat;
    logic [NLINES-1:0] evt;
    logic              rd_hit;
    logic              wr_hit;

    assign pin_vec = {pin_cd, pin_ri, pin_dsr, pin_cts};

    msr_sync #(
        .WIDTH  (NLINES),
        .STAGES (SYNC_STAGES),
        .RST_VAL('1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_vec),
        .q    (pin_sync)
    );

    msr_src_sel u_sel (
        .loop_en (loop_en),
        .ctrl_out(ctrl_out),
        .pin_sync(pin_sync),
        .stat    (cur_stat)
    );

    msr_delta_detect #(
        .RISE_ONLY(RISE_ONLY_MASK)
    ) u_det (
        .cur (cur_stat),
        .prev(st_q.stat),
        .evt (evt)
    );

    assign rd_hit = host_rd && (host_addr == STAT_ADDR);
    assign wr_hit = host_wr && (host_addr == STAT_ADDR);

    always_comb begin
        st_d      = st_q;
        st_d.stat = cur_stat;
        // new events win over a clearing read in the same cycle
        st_d.flag = (st_q.flag & ~{NLINES{rd_hit}}) | evt;
        if (rd_hit) begin
            st_d.rdata = {st_q.stat, st_q.flag};
        end else if (host_rd) begin
            st_d.rdata = '0;
        end
        if (wr_hit) begin
            st_d.feat = host_wdata;
        end
        st_d.irq = |st_d.flag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.rdata;
    assign feat_ctrl  = st_q.feat;
    assign msi_irq    = st_q.irq;
endmodule

// File: rtl/msr_checker.sv
module msr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       rd_hit,
    input logic [3:0] stat,
    input logic [3:0] flag,
    input logic       irq
);
    assert_irq_matches_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (flag != 4'b0));

    assert_ring_rise_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[2]) |-> $rose(stat[2]));

    assert_cts_flag_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag[0]) |-> !$stable(stat[0]));

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit ##1 $stable(stat) |-> flag == 4'b0);

    assert_flags_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> ((flag & $past(flag)) == $past(flag)));
endmodule

bind modem_status_reg msr_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rd_hit(rd_hit),
    .stat  (st_q.stat),
    .flag  (st_q.flag),
    .irq   (msi_irq)
);

// File: tb/tb_modem_status_reg.sv
module tb_modem_status_reg;
    localparam logic [2:0] STAT_A = 3'd6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] pins = 4'hF;   // {cd, ri, dsr, cts}
    logic       loop_en = 1'b0;
    logic [3:0] ctrl = '0;
    logic [7:0] feat;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] exp_stat = '0;
    logic [3:0] exp_flag = '0;

    always #2 clk = ~clk;

    modem_status_reg dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_addr (addr),
        .host_rd   (rd),
        .host_wr   (wr),
        .host_wdata(wdata),
        .host_rdata(rdata),
        .pin_cd    (pins[3]),
        .pin_ri    (pins[2]),
        .pin_dsr   (pins[1]),
        .pin_cts   (pins[0]),
        .loop_en   (loop_en),
        .ctrl_out  (ctrl),
        .feat_ctrl (feat),
        .msi_irq   (irq)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [3:0] nstat);
        exp_flag[3] |= nstat[3] ^ exp_stat[3];
        exp_flag[2] |= nstat[2] & ~exp_stat[2];
        exp_flag[1] |= nstat[1] ^ exp_stat[1];
        exp_flag[0] |= nstat[0] ^ exp_stat[0];
        exp_stat = nstat;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(input logic [2:0] a, output logic [7:0] v);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic do_write(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    function automatic logic [3:0] loop_map(input logic [3:0] c);
        return {c[3], c[2], c[0], c[1]};
    endfunction

    task automatic read_and_clear(input string tag);
        logic [7:0] v;
        chk({tag, " R7 irq before read"}, {7'b0, irq}, {7'b0, exp_flag != 4'b0});
        do_read(STAT_A, v);
        chk({tag, " R6 readback"}, v, {exp_stat, exp_flag});
        exp_flag = '0;
        chk({tag, " R7 irq after read"}, {7'b0, irq}, 8'h00);
    endtask

    initial begin
        #(200000 * 4);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        settle(3);
        rst_n = 1'b1;
        settle(4);
        // R1 reset state
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);
        chk("R1 feat", feat, 8'h00);
        do_read(STAT_A, v);
        chk("R1 status", v, 8'h00);

        // R12 synchronizer latency
        pins = 4'b0111;
        settle(2);
        chk("R12 not before third edge", {7'b0, irq}, 8'h00);
        settle(1);
        chk("R12 third edge", {7'b0, irq}, 8'h01);
        model(~pins);
        read_and_clear("R12");

        // R2 R4 sweep of all pin patterns, normal mode
        for (int k = 0; k < 16; k++) begin
            pins = 4'((k * 7 + 3) & 15);
            settle(4);
            model(~pins);
            read_and_clear("R2 R4 sweep");
            do_read(STAT_A, v);
            chk("R6 flags cleared", v, {exp_stat, 4'b0});
        end

        // R5 ring flag direction
        pins = 4'hF; settle(4); model(~pins); read_and_clear("R5 prep");
        pins = 4'b1011; settle(4); model(~pins);
        chk("R5 rising sets flag", {7'b0, irq}, 8'h01);
        read_and_clear("R5 rise");
        pins = 4'hF; settle(4); model(~pins);
        chk("R5 falling no irq", {7'b0, irq}, 8'h00);
        read_and_clear("R5 fall");

        // R9 enter loopback; R3 mapping sweep
        ctrl = 4'b1001; loop_en = 1'b1; settle(2);
        model(loop_map(ctrl));
        read_and_clear("R9 enter");
        for (int c = 0; c < 16; c++) begin
            ctrl = 4'((c * 5 + 1) & 15);
            settle(2);
            model(loop_map(ctrl));
            read_and_clear("R3 sweep");
        end
        // R3 pins ignored in loopback
        pins = 4'h0; settle(4);
        chk("R3 pins ignored irq", {7'b0, irq}, 8'h00);
        do_read(STAT_A, v);
        chk("R3 pins ignored data", v, {exp_stat, 4'b0});
        pins = 4'hF; settle(4);
        // R9 leave loopback
        ctrl = 4'b1111; settle(2); model(loop_map(ctrl)); read_and_clear("R9 prep");
        loop_en = 1'b0; settle(2); model(~pins);
        read_and_clear("R9 leave");

        // R8 change in the same cycle as a clearing read
        loop_en = 1'b1; ctrl = 4'b0000; settle(2); model(loop_map(ctrl));
        read_and_clear("R8 prep");
        ctrl = 4'b1000; settle(2); model(loop_map(ctrl));
        ctrl = 4'b1010;
        do_read(STAT_A, v);
        chk("R8 read shows old flags", v, {exp_stat, exp_flag});
        exp_flag = '0;
        model(loop_map(ctrl));
        chk("R8 irq kept", {7'b0, irq}, 8'h01);
        read_and_clear("R8 new flag kept");

        // R10 write goes to feature register
        ctrl = 4'b1011; settle(2); model(loop_map(ctrl));
        do_write(STAT_A, 8'hA5);
        chk("R10 feature loaded", feat, 8'hA5);
        do_write(3'd2, 8'h3C);
        chk("R10 other address no load", feat, 8'hA5);
        read_and_clear("R10 flags untouched");

        // R11 foreign read
        ctrl = 4'b0011; settle(2); model(loop_map(ctrl));
        do_read(3'd1, v);
        chk("R11 foreign read data", v, 8'h00);
        chk("R11 irq kept", {7'b0, irq}, 8'h01);
        read_and_clear("R11 flags kept");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule